// File: doc/BRIEF.md
# PCI Bridge Address Window Translator

This block holds the address-window register file of a PCI host bridge and uses it to translate addresses both ways. Four outbound windows map CPU-side addresses onto the PCI bus. Three inbound windows map addresses from PCI bus masters onto local memory. A 32-bit register port reads and writes the window registers and a general timer register. Writes take one clock. Reads are combinational on the offset.

Two combinational lookup ports each take a 44-bit address and return a hit flag and the translated address. Base and translation registers hold page numbers: the register value shifted up by 12 bits. A window's size is set by a 6-bit exponent in its attribute register. When several outbound windows claim an address, the lowest slot wins. An inbound address that no window claims passes through unchanged, because identity mapping sits below every inbound window in priority.

Top module: `bridge_window_xlate`

## Requirements
- R1: After synchronous reset every register reads zero, the outbound port reports no hit with a translated address of zero, and the inbound port passes its address through unchanged.
- R2: Outbound slots 0 to 3 answer at offsets 0xC20, 0xC40, 0xC60 and 0xC80, with the slot selected by offset bits [11:5]. Within a slot, +0x0 is the translation page, +0x4 the extended translation, +0x8 the base page and +0x10 the attributes. Each reads back the full 32-bit value written.
- R3: Inbound slots 0, 1 and 2 answer at offsets 0xDA0, 0xDC0 and 0xDE0. Within a slot, +0x0 is the translation page, +0x8 the base page, +0xC the extended base and +0x10 the attributes. Each reads back the full 32-bit value written.
- R4: Any offset from 0xE20 to 0xE3F reads and writes one 32-bit timer storage register.
- R5: Every other offset reads zero, and a write to it changes no register and no lookup result. This covers offsets below 0xC20, the +0xC and +0x14..+0x1C holes of an outbound slot, and the +0x4 and +0x14..+0x1C holes of an inbound slot.
- R6: Attribute bit 31 enables a window and bits [5:0] hold n. An enabled window hits when (address - base<<12) mod 2^44 is less than 2<<n. When n+1 >= 44 the window covers the whole space. A disabled window never hits.
- R7: A hitting window translates to (translation<<12 + address - base<<12) mod 2^44.
- R8: Among outbound windows that hit, the lowest slot supplies the result. With no hit the outbound translated address is zero.
- R9: Among inbound windows that hit, the lowest slot supplies the result. With no hit the inbound flag is low and the address passes through unchanged.
- R10: A register write changes the lookup result from the clock edge that stores it, so it is visible in the very next cycle.
- R11: The extended translation and extended base registers are storage only and do not affect hits or translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset in the 4 KB control space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr | input | 44 | CPU-side address to translate outbound |
| ob_hit | output | 1 | Some outbound window claims ob_addr |
| ob_xaddr | output | 44 | PCI-side address, zero on a miss |
| ib_addr | input | 44 | PCI-side address to translate inbound |
| ib_hit | output | 1 | Some inbound window claims ib_addr |
| ib_xaddr | output | 44 | Local address, or ib_addr on a miss |

## Verification
The hardest cases to reach are windows that overlap, where priority decides the result, and the edges of a window. These edges are the last byte inside, the first byte past the end, an address just below the base whose offset wraps to a huge value, and an exponent so large that the window covers the whole space. Directed writes stack two outbound windows and two inbound windows on the same pages, probe each edge, and then disable the winning slot so the next slot takes over in the following cycle. Random writes then keep bases within a few dozen pages and exponents between 2^11 and 2^18 bytes, so that random lookups often land in overlaps and on window edges.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    localparam int CW      = 32;          // register width
    localparam int PAGE_SH = 12;          // base/translation granule shift
    localparam int XW      = CW + PAGE_SH; // translated address width

    // window groups, selected by offset bits [11:5]
    localparam logic [6:0] OB_GRP0 = 7'h61; // 0xC20
    localparam logic [6:0] IB_GRP0 = 7'h6D; // 0xDA0
    localparam logic [6:0] TMR_GRP = 7'h71; // 0xE20

    // storage slot order inside a window: 0 translation, 1 extension, 2 base, 3 attributes
    typedef struct packed {
        logic       ok;
        logic [1:0] idx;
    } fsel_t;

    typedef struct packed {
        logic          en;
        logic [5:0]    sz;
        logic [CW-1:0] base;
        logic [CW-1:0] tar;
    } win_cfg_t;

    function automatic fsel_t ob_field(input logic [4:0] off);
        case (off)
            5'h00:   return '{ok: 1'b1, idx: 2'd0};
            5'h04:   return '{ok: 1'b1, idx: 2'd1};
            5'h08:   return '{ok: 1'b1, idx: 2'd2};
            5'h10:   return '{ok: 1'b1, idx: 2'd3};
            default: return '{ok: 1'b0, idx: 2'd0};
        endcase
    endfunction

    function automatic fsel_t ib_field(input logic [4:0] off);
        case (off)
            5'h00:   return '{ok: 1'b1, idx: 2'd0};
            5'h0C:   return '{ok: 1'b1, idx: 2'd1};
            5'h08:   return '{ok: 1'b1, idx: 2'd2};
            5'h10:   return '{ok: 1'b1, idx: 2'd3};
            default: return '{ok: 1'b0, idx: 2'd0};
        endcase
    endfunction

    function automatic win_cfg_t cfg_of(input logic [3:0][CW-1:0] r);
        win_cfg_t c;
        c.en   = r[3][CW-1];
        c.sz   = r[3][5:0];
        c.base = r[2];
        c.tar  = r[0];
        return c;
    endfunction

endpackage

// File: rtl/bwx_regfile.sv
module bwx_regfile
    import bwx_pkg::*;
#(
    parameter int N_OB = 4,
    parameter int N_IB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [11:0]   addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output win_cfg_t      ob_cfg [N_OB],
    output win_cfg_t      ib_cfg [N_IB]
);

    logic [6:0]      grp;
    fsel_t           ob_fs, ib_fs;
    logic [N_OB-1:0] ob_sel;
    logic [N_IB-1:0] ib_sel;
    logic            tmr_sel;

    logic [3:0][CW-1:0] ob_q [N_OB];
    logic [3:0][CW-1:0] ib_q [N_IB];
    logic [CW-1:0]      tmr_q;

    assign grp     = addr[11:5];
    assign ob_fs   = ob_field(addr[4:0]);
    assign ib_fs   = ib_field(addr[4:0]);
    assign tmr_sel = (grp == TMR_GRP);

    for (genvar i = 0; i < N_OB; i++) begin : g_ob
        assign ob_sel[i] = (grp == 7'(int'(OB_GRP0) + i));
        always_ff @(posedge clk) begin
            if (rst)
                ob_q[i] <= '0;
            else if (wen && ob_sel[i] && ob_fs.ok)
                ob_q[i][ob_fs.idx] <= wdata;
        end
        assign ob_cfg[i] = cfg_of(ob_q[i]);

        // R5
        unmapped_ob_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wen && addr < 12'hC20) |=> $stable(ob_q[i]));
    end

    for (genvar j = 0; j < N_IB; j++) begin : g_ib
        assign ib_sel[j] = (grp == 7'(int'(IB_GRP0) + j));
        always_ff @(posedge clk) begin
            if (rst)
                ib_q[j] <= '0;
            else if (wen && ib_sel[j] && ib_fs.ok)
                ib_q[j][ib_fs.idx] <= wdata;
        end
        assign ib_cfg[j] = cfg_of(ib_q[j]);

        // R5
        unmapped_ib_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wen && addr < 12'hC20) |=> $stable(ib_q[j]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else if (wen && tmr_sel)
            tmr_q <= wdata;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_OB; i++)
            if (ob_sel[i] && ob_fs.ok) rdata = ob_q[i][ob_fs.idx];
        for (int j = 0; j < N_IB; j++)
            if (ib_sel[j] && ib_fs.ok) rdata = ib_q[j][ib_fs.idx];
        if (tmr_sel) rdata = tmr_q;
    end

    // R4
    timer_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && tmr_sel) |=> (tmr_q == $past(wdata)));

endmodule

// File: rtl/bwx_window.sv
module bwx_window
    import bwx_pkg::*;
(
    input  win_cfg_t        cfg,
    input  logic [XW-1:0]   addr,
    output logic            hit,
    output logic [XW-1:0]   xaddr
);

    logic [XW-1:0] offs;
    logic [6:0]    span_sh;

    assign offs    = addr - {cfg.base, {PAGE_SH{1'b0}}};
    assign span_sh = {1'b0, cfg.sz} + 7'd1;
    // shifting out every significant bit means offs < 2 << sz
    assign hit     = cfg.en && ((offs >> span_sh) == '0);
    assign xaddr   = {cfg.tar, {PAGE_SH{1'b0}}} + offs;

endmodule

// File: rtl/bwx_pick.sv
module bwx_pick
    import bwx_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]  hit,
    input  logic [XW-1:0] cand [N],
    output logic          any,
    output logic [XW-1:0] sel
);

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit[i]) sel = cand[i];
    end

    assign any = |hit;

endmodule

// File: rtl/bridge_window_xlate.sv
module bridge_window_xlate
    import bwx_pkg::*;
#(
    parameter int N_OB = 4,
    parameter int N_IB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wen,
    input  logic [11:0]   reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [43:0]   ob_addr,
    output logic          ob_hit,
    output logic [43:0]   ob_xaddr,
    input  logic [43:0]   ib_addr,
    output logic          ib_hit,
    output logic [43:0]   ib_xaddr
);

    win_cfg_t        ob_cfg [N_OB];
    win_cfg_t        ib_cfg [N_IB];
    logic [N_OB-1:0] ob_whit;
    logic [N_IB-1:0] ib_whit;
    logic [XW-1:0]   ob_cand [N_OB];
    logic [XW-1:0]   ib_cand [N_IB];
    logic [XW-1:0]   ib_sel;
    logic            ib_any;
    logic [N_OB-1:0] ob_en;
    logic [N_IB-1:0] ib_en;

    bwx_regfile #(.N_OB(N_OB), .N_IB(N_IB)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wen    (reg_wen),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ob_cfg (ob_cfg),
        .ib_cfg (ib_cfg)
    );

    for (genvar i = 0; i < N_OB; i++) begin : g_obw
        bwx_window u_win (
            .cfg   (ob_cfg[i]),
            .addr  (ob_addr),
            .hit   (ob_whit[i]),
            .xaddr (ob_cand[i])
        );
        assign ob_en[i] = ob_cfg[i].en;
    end

    for (genvar j = 0; j < N_IB; j++) begin : g_ibw
        bwx_window u_win (
            .cfg   (ib_cfg[j]),
            .addr  (ib_addr),
            .hit   (ib_whit[j]),
            .xaddr (ib_cand[j])
        );
        assign ib_en[j] = ib_cfg[j].en;
    end

    bwx_pick #(.N(N_OB)) u_ob_pick (
        .hit  (ob_whit),
        .cand (ob_cand),
        .any  (ob_hit),
        .sel  (ob_xaddr)
    );

    bwx_pick #(.N(N_IB)) u_ib_pick (
        .hit  (ib_whit),
        .cand (ib_cand),
        .any  (ib_any),
        .sel  (ib_sel)
    );

    // identity mapping below every inbound window
    assign ib_hit   = ib_any;
    assign ib_xaddr = ib_any ? ib_sel : ib_addr;

    // R6
    ob_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ob_hit |-> (ob_en != '0));

    // R6
    ib_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ib_hit |-> (ib_en != '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ob_hit && !ib_hit && reg_rdata == '0));

endmodule

// File: tb/tb_bridge_window_xlate.sv
module tb_bridge_window_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [43:0] ob_addr = '0;
    logic        ob_hit;
    logic [43:0] ob_xaddr;
    logic [43:0] ib_addr = '0;
    logic        ib_hit;
    logic [43:0] ib_xaddr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bridge_window_xlate dut (
        .clk(clk), .rst(rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ob_addr(ob_addr), .ob_hit(ob_hit), .ob_xaddr(ob_xaddr),
        .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_xaddr(ib_xaddr)
    );

    // reference model, named by role
    logic [31:0] m_ob_tar [4], m_ob_tarx [4], m_ob_base [4], m_ob_attr [4];
    logic [31:0] m_ib_tar [3], m_ib_basex [3], m_ib_base [3], m_ib_attr [3];
    logic [31:0] m_tmr;

    function automatic logic [31:0] ref_rd(input logic [11:0] a);
        int g = int'(a[11:5]);
        logic [4:0] o = a[4:0];
        if (g >= 'h61 && g <= 'h64) begin
            int k = g - 'h61;
            if (o == 5'h00) return m_ob_tar[k];
            if (o == 5'h04) return m_ob_tarx[k];
            if (o == 5'h08) return m_ob_base[k];
            if (o == 5'h10) return m_ob_attr[k];
        end else if (g >= 'h6D && g <= 'h6F) begin
            int k = g - 'h6D;
            if (o == 5'h00) return m_ib_tar[k];
            if (o == 5'h08) return m_ib_base[k];
            if (o == 5'h0C) return m_ib_basex[k];
            if (o == 5'h10) return m_ib_attr[k];
        end else if (g == 'h71) return m_tmr;
        return 32'h0;
    endfunction

    task automatic ref_wr(input logic [11:0] a, input logic [31:0] d);
        int g = int'(a[11:5]);
        logic [4:0] o = a[4:0];
        if (g >= 'h61 && g <= 'h64) begin
            int k = g - 'h61;
            if (o == 5'h00) m_ob_tar[k] = d;
            if (o == 5'h04) m_ob_tarx[k] = d;
            if (o == 5'h08) m_ob_base[k] = d;
            if (o == 5'h10) m_ob_attr[k] = d;
        end else if (g >= 'h6D && g <= 'h6F) begin
            int k = g - 'h6D;
            if (o == 5'h00) m_ib_tar[k] = d;
            if (o == 5'h08) m_ib_base[k] = d;
            if (o == 5'h0C) m_ib_basex[k] = d;
            if (o == 5'h10) m_ib_attr[k] = d;
        end else if (g == 'h71) m_tmr = d;
    endtask

    function automatic bit ref_in(input logic [31:0] attr, input logic [31:0] base,
                                  input logic [43:0] a);
        logic [43:0] d = a - {base, 12'h000};
        int n = int'(attr[5:0]);
        if (!attr[31]) return 1'b0;
        if (n + 1 >= 44) return 1'b1;
        return d < (44'd1 << (n + 1));
    endfunction

    function automatic logic [43:0] ref_map(input logic [31:0] tar, input logic [31:0] base,
                                            input logic [43:0] a);
        return {tar, 12'h000} + (a - {base, 12'h000});
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
        ref_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        reg_addr = a;
        #1;
        chk(req, 64'(reg_rdata), 64'(ref_rd(a)));
    endtask

    task automatic ob_chk(input string req, input logic [43:0] a);
        bit eh = 0;
        logic [43:0] ex = '0;
        ob_addr = a;
        #1;
        for (int k = 3; k >= 0; k--)
            if (ref_in(m_ob_attr[k], m_ob_base[k], a)) begin
                eh = 1; ex = ref_map(m_ob_tar[k], m_ob_base[k], a);
            end
        chk(req, 64'(ob_hit), 64'(eh));
        chk(req, 64'(ob_xaddr), 64'(ex));
    endtask

    task automatic ib_chk(input string req, input logic [43:0] a);
        bit eh = 0;
        logic [43:0] ex = a;
        ib_addr = a;
        #1;
        for (int k = 2; k >= 0; k--)
            if (ref_in(m_ib_attr[k], m_ib_base[k], a)) begin
                eh = 1; ex = ref_map(m_ib_tar[k], m_ib_base[k], a);
            end
        chk(req, 64'(ib_hit), 64'(eh));
        chk(req, 64'(ib_xaddr), 64'(ex));
    endtask

    function automatic logic [11:0] pick_addr();
        logic [11:0] grps [9] = '{12'hC20, 12'hC40, 12'hC60, 12'hC80,
                                  12'hDA0, 12'hDC0, 12'hDE0, 12'hE20, 12'h400};
        logic [4:0]  offs [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h10, 5'h14};
        return grps[$urandom % 9] | 12'(offs[$urandom % 7]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) begin
            m_ob_tar[k] = 0; m_ob_tarx[k] = 0; m_ob_base[k] = 0; m_ob_attr[k] = 0;
        end
        for (int k = 0; k < 3; k++) begin
            m_ib_tar[k] = 0; m_ib_basex[k] = 0; m_ib_base[k] = 0; m_ib_attr[k] = 0;
        end
        m_tmr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1", 12'hC30);
        rd_chk("R1", 12'hDF0);
        rd_chk("R1", 12'hE20);
        ob_chk("R1", 44'h0_0000_0000);
        chk("R1", 64'(ob_xaddr), 64'h0);
        ib_chk("R1", 44'hABC_1234_5678);
        chk("R1", 64'(ib_xaddr), 64'hABC_1234_5678);

        // R2 / R6 / R7: slot 0 at base page 0x10, n=12 (8 KB), translation 0xABC
        wr(12'hC20, 32'h0000_0ABC);
        wr(12'hC28, 32'h0000_0010);
        wr(12'hC30, 32'h8000_000C);
        rd_chk("R2", 12'hC28);
        rd_chk("R2", 12'hC30);
        ob_chk("R6", 44'h000_0001_0000);
        chk("R7", 64'(ob_xaddr), 64'h0AB_C000);
        ob_chk("R6", 44'h000_0001_1FFF);
        chk("R7", 64'(ob_xaddr), 64'h0AB_DFFF);
        ob_chk("R6", 44'h000_0001_2000);
        chk("R6", 64'(ob_hit), 64'h0);
        ob_chk("R6", 44'h000_0000_FFFF);
        chk("R6", 64'(ob_hit), 64'h0);

        // R8: slot 1 overlaps, slot 0 wins
        wr(12'hC40, 32'h0000_0005);
        wr(12'hC48, 32'h0000_0010);
        wr(12'hC50, 32'h8000_0014);
        ob_chk("R8", 44'h000_0001_0004);
        chk("R8", 64'(ob_xaddr), 64'h0AB_C004);
        // R10: disable slot 0, slot 1 takes over next cycle
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 12'hC30; reg_wdata = 32'h0000_000C;
        @(negedge clk);
        reg_wen = 1'b0;
        ref_wr(12'hC30, 32'h0000_000C);
        ob_chk("R10", 44'h000_0001_0004);
        chk("R10", 64'(ob_xaddr), 64'h000_5004);

        // R11: extended translation has no effect
        wr(12'hC44, 32'hFFFF_FFFF);
        rd_chk("R11", 12'hC44);
        ob_chk("R11", 44'h000_0001_0004);
        chk("R11", 64'(ob_xaddr), 64'h000_5004);

        // R6: n=43 covers everything
        wr(12'hC68, 32'hFFFF_F000);
        wr(12'hC70, 32'h8000_002B);
        ob_chk("R6", 44'hFFF_FFFF_FFFF);
        chk("R6", 64'(ob_hit), 64'h1);
        ob_chk("R6", 44'h000_0000_0123);
        wr(12'hC70, 32'h0000_002B);

        // R3 / R9: inbound slots 0 and 2 overlap, slot 0 (0xDA0) wins
        wr(12'hDA0, 32'h0000_0300);
        wr(12'hDA8, 32'h0000_0020);
        wr(12'hDB0, 32'h8000_000E);
        wr(12'hDE0, 32'h0000_0700);
        wr(12'hDE8, 32'h0000_0020);
        wr(12'hDF0, 32'h8000_000E);
        wr(12'hDAC, 32'h1234_5678);
        rd_chk("R3", 12'hDA0);
        rd_chk("R3", 12'hDAC);
        rd_chk("R3", 12'hDF0);
        ib_chk("R9", 44'h000_0002_0010);
        chk("R9", 64'(ib_xaddr), 64'h030_0010);
        ib_chk("R9", 44'h000_0009_0000);
        chk("R9", 64'(ib_xaddr), 64'h9_0000);
        wr(12'hDB0, 32'h0000_000E);
        ib_chk("R9", 44'h000_0002_0010);
        chk("R9", 64'(ib_xaddr), 64'h070_0010);

        // R4: timer over its whole group
        wr(12'hE20, 32'hCAFE_F00D);
        rd_chk("R4", 12'hE20);
        rd_chk("R4", 12'hE3C);
        chk("R4", 64'(reg_rdata), 64'hCAFE_F00D);

        // R5: holes and unmapped offsets
        wr(12'hC2C, 32'hDEAD_BEEF);
        rd_chk("R5", 12'hC2C);
        chk("R5", 64'(reg_rdata), 64'h0);
        wr(12'hDA4, 32'hDEAD_BEEF);
        rd_chk("R5", 12'hDA4);
        wr(12'hC08, 32'h0000_0099);
        rd_chk("R5", 12'hC08);
        rd_chk("R5", 12'hC48);
        ob_chk("R5", 44'h000_0001_0004);
        ib_chk("R5", 44'h000_0002_0010);

        // random mix
        for (int it = 0; it < 500; it++) begin
            logic [11:0] a = pick_addr();
            logic [31:0] d;
            if (a[4:0] == 5'h10)
                d = {($urandom % 4) != 0, 25'($urandom), 6'(10 + $urandom % 8)};
            else if (a[4:0] == 5'h08)
                d = 32'($urandom % 24);
            else
                d = $urandom;
            wr(a, d);
            rd_chk("R2", a);
            ob_chk("R8", {32'($urandom % 40), 12'($urandom)});
            ib_chk("R9", {32'($urandom % 40), 12'($urandom)});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule